// File: doc/BRIEF.md
# Configuration-Memory Test Access Port Controller

This block is the boundary-scan test access port of a configuration memory. It runs the standard sixteen-state test-port state machine, steered by TMS on each rising edge of TCK. It has an eight-bit instruction register, a one-bit bypass path, and two 32-bit identification paths: a fixed device identity and a user-programmed code. The instruction register is decoded into four results: a request to float all outputs, a request to hold the pins from the boundary register, a select that routes the external boundary chain into the scan path, and a single timed low pulse on an open-drain line that starts configuration of the attached programmable logic.

The controller runs on a free-running system clock. TCK, TMS and TDI pass through a short synchronizer, and the controller acts on the TCK edges it detects, so TCK must run well below the system clock. Two status inputs from the memory core are placed into the instruction capture pattern: in-system-programming mode and the read-protection bit. The read-protection bit also blocks read and verify requests from the programming engine. Program and erase requests do not pass through this gate.

Top module: `cfgmem_tap`

## Requirements
- R1: The state machine follows the standard sixteen-state test-port graph on detected TCK rising edges. Five TCK rises with TMS high reach Test-Logic-Reset from any state, and that state makes IDCODE (8'hFE) the current instruction.
- R2: In Capture-IR the instruction shift register loads bits [7:5]=000, bit 4 = isp_mode, bit 3 = read_secure, bit 2 = 0 and bits [1:0]=01. This pattern leaves on tdo least significant bit first while the new opcode enters from tdi.
- R3: The IDCODE instruction (8'hFE) captures {version[31:28], family[27:20], product[19:12], maker[11:1], 1'b1}. The default value is 32'h05026093, and it shifts out LSB first.
- R4: The USERCODE instruction (8'hFD) captures the 32-bit usercode input, which reads 32'hFFFFFFFF on a blank device.
- R5: BYPASS (8'hFF) and every opcode not listed in these requirements select a one-bit register. That register captures 0 and then passes tdi to tdo with one TCK of delay.
- R6: HIGHZ (8'hFC) raises highz_req and CLAMP (8'hFA) raises clamp_req. Both use the bypass register as the data path, and every other instruction keeps both requests low.
- R7: EXTEST (8'h00) and SAMPLE/PRELOAD (8'h01) raise bscan_sel, and in Shift-DR tdo carries bsr_so.
- R8: Each Update-IR that installs CONFIG (8'hEE) drives cfg_n low once, for exactly PULSE_CYC system clocks (20 cycles, 400 ns at 50 MHz). No other instruction and no idle time under CONFIG produces a pulse.
- R9: rd_grant equals the previous cycle's rd_req, but only while the previous cycle's read_secure was low. With read_secure high, rd_grant stays low.
- R10: tdo_oe is high only while the controller is in Shift-IR or Shift-DR. tdo and tdo_oe change only after a detected TCK falling edge.
- R11: After reset, cfg_n is high, tdo_oe is low, and the current instruction is IDCODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tck | input | 1 | Test clock, asynchronous to clk |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, valid while tdo_oe is high |
| tdo_oe | output | 1 | Output enable for tdo |
| isp_mode | input | 1 | Core is in programming mode |
| read_secure | input | 1 | Read-protection bit from the core |
| usercode | input | 32 | User-programmed identification word |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| highz_req | output | 1 | Request to float all device outputs |
| clamp_req | output | 1 | Request to drive pins from the boundary register |
| bscan_sel | output | 1 | Boundary chain is the selected data path |
| cfg_n | output | 1 | Active-low configuration trigger (open-drain drive) |
| rd_req | input | 1 | Read or verify request from the programming engine |
| rd_grant | output | 1 | Read or verify permitted |

## Verification
Each scan result is due one TCK after the edge that produces it. State and shift actions occur on a detected TCK rise, which lands three system clocks after the pin edge. tdo and tdo_oe follow a detected TCK fall by the same lag. The bench holds each TCK phase for six system clocks and samples tdo and the decode outputs just before it raises TCK, which is after the fall settles and before the next rise is seen. rd_grant is due one system clock after its inputs, so the bench compares it on every clock against the values captured at the previous edge. The width of each cfg_n pulse is counted in system clocks and compared against PULSE_CYC once the line returns high.

// File: rtl/cfgtap_pkg.sv
// Shared types, opcodes and the test-port next-state function.
// Assumes an eight-bit instruction register and 32-bit identification words.
package cfgtap_pkg;

    localparam int IR_W = 8;
    localparam int DR_W = 32;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_USER, DR_BSCAN} dr_sel_t;

    localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
    localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;
    localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
    localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
    localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
    localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;

    // Standard sixteen-state transition graph.
    function automatic tap_state_t tap_next(tap_state_t s, logic m);
        case (s)
            S_TLR:    return m ? S_TLR    : S_RTI;
            S_RTI:    return m ? S_SEL_DR : S_RTI;
            S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: return m ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  return m ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: return m ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: return m ? S_SEL_DR : S_RTI;
            S_SEL_IR: return m ? S_TLR    : S_CAP_IR;
            S_CAP_IR: return m ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  return m ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: return m ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: return m ? S_SEL_DR : S_RTI;
            default:  return S_TLR;
        endcase
    endfunction

endpackage

// File: rtl/cfgtap_sync.sv
// Brings tck, tms and tdi into the clk domain through STAGES flops and
// flags detected tck edges. Assumes tck is held stable for STAGES+1 clk
// periods per phase and that tms/tdi are stable around each tck rise.
module cfgtap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    output logic tck_rise,
    output logic tck_fall,
    output logic tms_s,
    output logic tdi_s
);
    localparam int LAST = STAGES - 1;

    logic [2:0] pipe [STAGES];
    logic       tck_q;

    // Synchronizer chain for all three pins, kept aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= {tck, tms, tdi};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    // Previous synchronized tck for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tck_q <= 1'b0;
        else        tck_q <= pipe[LAST][2];
    end

    assign tck_rise = pipe[LAST][2] & ~tck_q;
    assign tck_fall = ~pipe[LAST][2] & tck_q;
    assign tms_s    = pipe[LAST][1];
    assign tdi_s    = pipe[LAST][0];
endmodule

// File: rtl/cfgtap_ir.sv
// Instruction register: capture of the status pattern, shift, update and
// decode into data-path select and pin-control requests. Raises cfg_fire
// for the one clk where CONFIG is installed. Assumes state changes only on
// tck_rise.
module cfgtap_ir
    import cfgtap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tck_rise,
    input  tap_state_t state,
    input  logic       tdi_s,
    input  logic       isp_mode,
    input  logic       read_secure,
    output logic       ir_lsb,
    output dr_sel_t    dr_sel,
    output logic       highz_req,
    output logic       clamp_req,
    output logic       bscan_sel,
    output logic       cfg_fire
);
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_cur;
    logic [IR_W-1:0] cap_pat;

    assign cap_pat = {3'b000, isp_mode, read_secure, 1'b0, 2'b01};

    // Shift register and current instruction, advanced on tck rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_sh  <= '0;
            ir_cur <= OP_IDCODE;
        end else if (tck_rise) begin
            case (state)
                S_TLR:    ir_cur <= OP_IDCODE;
                S_CAP_IR: ir_sh  <= cap_pat;
                S_SH_IR:  ir_sh  <= {tdi_s, ir_sh[IR_W-1:1]};
                S_UPD_IR: ir_cur <= ir_sh;
                default:  ;
            endcase
        end
    end

    assign ir_lsb   = ir_sh[0];
    assign cfg_fire = tck_rise && (state == S_UPD_IR) && (ir_sh == OP_CONFIG);

    // Decode of the installed instruction; unknown codes fall to bypass.
    always_comb begin
        dr_sel    = DR_BYPASS;
        highz_req = 1'b0;
        clamp_req = 1'b0;
        bscan_sel = 1'b0;
        case (ir_cur)
            OP_IDCODE:   dr_sel = DR_IDCODE;
            OP_USERCODE: dr_sel = DR_USER;
            OP_EXTEST, OP_SAMPLE: begin
                dr_sel    = DR_BSCAN;
                bscan_sel = 1'b1;
            end
            OP_HIGHZ:    highz_req = 1'b1;
            OP_CLAMP:    clamp_req = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/cfgtap_dr.sv
// Data registers: the one-bit bypass stage and a shared 32-bit shifter
// loaded with either identity word. Boundary data is external and is
// muxed at the top. Assumes dr_sel is stable during a data scan.
module cfgtap_dr
    import cfgtap_pkg::*;
#(
    parameter logic [DR_W-1:0] ID_VALUE = 32'h05026093
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tck_rise,
    input  tap_state_t      state,
    input  dr_sel_t         dr_sel,
    input  logic            tdi_s,
    input  logic [DR_W-1:0] usercode,
    output logic            dr_lsb
);
    logic            byp;
    logic [DR_W-1:0] dr_sh;

    // Capture and shift on tck rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp   <= 1'b0;
            dr_sh <= '0;
        end else if (tck_rise) begin
            if (state == S_CAP_DR) begin
                byp <= 1'b0;
                case (dr_sel)
                    DR_IDCODE: dr_sh <= ID_VALUE;
                    DR_USER:   dr_sh <= usercode;
                    default:   dr_sh <= '0;
                endcase
            end else if (state == S_SH_DR) begin
                byp   <= tdi_s;
                dr_sh <= {tdi_s, dr_sh[DR_W-1:1]};
            end
        end
    end

    assign dr_lsb = (dr_sel == DR_BYPASS) ? byp : dr_sh[0];
endmodule

// File: rtl/cfgtap_pulse.sv
// One-shot low pulse of PULSE_CYC clk cycles on each fire. A fire that
// arrives while a pulse is running is dropped. Assumes PULSE_CYC >= 1.
module cfgtap_pulse #(
    parameter int PULSE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic cfg_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // Down-counter that holds the line low while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (fire && cnt == '0)      cnt <= CW'(PULSE_CYC);
        else if (cnt != '0)              cnt <= cnt - 1'b1;
    end

    assign cfg_n = (cnt == '0);
endmodule

// File: rtl/cfgmem_tap.sv
// Top of the configuration-memory test port. Owns the state register, the
// tdo output stage, which updates on detected tck falls, and the
// read-protection gate. Assumes tck runs at most clk/8.
module cfgmem_tap
    import cfgtap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION  = 4'h0,
    parameter logic [7:0]  ID_FAMILY   = 8'h50,
    parameter logic [7:0]  ID_PART     = 8'h26,
    parameter logic [10:0] ID_MAKER    = 11'h049,
    parameter int          PULSE_CYC   = 20,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tck,
    input  logic        tms,
    input  logic        tdi,
    output logic        tdo,
    output logic        tdo_oe,
    input  logic        isp_mode,
    input  logic        read_secure,
    input  logic [31:0] usercode,
    input  logic        bsr_so,
    output logic        highz_req,
    output logic        clamp_req,
    output logic        bscan_sel,
    output logic        cfg_n,
    input  logic        rd_req,
    output logic        rd_grant
);
    localparam logic [DR_W-1:0] ID_VALUE = {ID_VERSION, ID_FAMILY, ID_PART, ID_MAKER, 1'b1};

    logic       tck_rise, tck_fall, tms_s, tdi_s;
    tap_state_t state;
    dr_sel_t    dr_sel;
    logic       ir_lsb, dr_lsb, cfg_fire;

    cfgtap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
        .tck_rise(tck_rise), .tck_fall(tck_fall), .tms_s(tms_s), .tdi_s(tdi_s)
    );

    // Test-port state register.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= S_TLR;
        else if (tck_rise) state <= tap_next(state, tms_s);
    end

    cfgtap_ir u_ir (
        .clk(clk), .rst_n(rst_n), .tck_rise(tck_rise), .state(state),
        .tdi_s(tdi_s), .isp_mode(isp_mode), .read_secure(read_secure),
        .ir_lsb(ir_lsb), .dr_sel(dr_sel), .highz_req(highz_req),
        .clamp_req(clamp_req), .bscan_sel(bscan_sel), .cfg_fire(cfg_fire)
    );

    cfgtap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
        .clk(clk), .rst_n(rst_n), .tck_rise(tck_rise), .state(state),
        .dr_sel(dr_sel), .tdi_s(tdi_s), .usercode(usercode), .dr_lsb(dr_lsb)
    );

    cfgtap_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(cfg_fire), .cfg_n(cfg_n)
    );

    // tdo stage, updated on tck falls only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdo    <= 1'b1;
            tdo_oe <= 1'b0;
        end else if (tck_fall) begin
            tdo_oe <= (state == S_SH_IR) || (state == S_SH_DR);
            if (state == S_SH_IR)        tdo <= ir_lsb;
            else if (state == S_SH_DR)   tdo <= (dr_sel == DR_BSCAN) ? bsr_so : dr_lsb;
            else                         tdo <= 1'b1;
        end
    end

    // Read/verify gate: blocked while the protection bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_grant <= 1'b0;
        else        rd_grant <= rd_req & ~read_secure;
    end
endmodule

// File: rtl/cfgmem_tap_chk.sv
// Property checker for cfgmem_tap, attached by bind. Observes ports and the
// detected tck edges; measures cfg_n pulse width with a counter.
module cfgmem_tap_chk #(
    parameter int PULSE_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic tck_rise,
    input logic tck_fall,
    input logic tdo,
    input logic tdo_oe,
    input logic cfg_n,
    input logic rd_req,
    input logic read_secure,
    input logic rd_grant,
    input logic highz_req,
    input logic clamp_req,
    input logic bscan_sel
);
    int low_run;

    // Length of the current low run on cfg_n.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_run <= 0;
        else if (!cfg_n) low_run <= low_run + 1;
        else             low_run <= 0;
    end

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_n) |-> (low_run == PULSE_CYC));

    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_n) |-> $past(tck_rise));

    assert_tdo_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tdo != $past(tdo)) |-> $past(tck_fall));

    assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tdo_oe != $past(tdo_oe)) |-> $past(tck_fall));

    assert_rd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> ($past(rd_req) && !$past(read_secure)));

    assert_secure_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(read_secure) |-> !rd_grant);

    assert_pin_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({highz_req, clamp_req, bscan_sel}));

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_n && !tdo_oe));
endmodule

bind cfgmem_tap cfgmem_tap_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .tdo(tdo), .tdo_oe(tdo_oe), .cfg_n(cfg_n), .rd_req(rd_req),
    .read_secure(read_secure), .rd_grant(rd_grant), .highz_req(highz_req),
    .clamp_req(clamp_req), .bscan_sel(bscan_sel)
);

// File: tb/tb_cfgmem_tap.sv
// Bench with a behavioural test-port model, stepped once per TCK and
// compared at every step, plus per-clock read-gate and pulse monitors.
module tb_cfgmem_tap;
    localparam int HALF = 6;
    localparam int PW   = 20;
    localparam logic [31:0] IDV = 32'h05026093;

    // bench-side state numbering
    localparam int T_RST = 0, T_IDLE = 1, T_SDR = 2, T_CDR = 3, T_SHD = 4, T_E1D = 5,
                   T_PD = 6, T_E2D = 7, T_UDR = 8, T_SIR = 9, T_CIR = 10, T_SHI = 11,
                   T_E1I = 12, T_PI = 13, T_E2I = 14, T_UIR = 15;

    logic clk = 0, rst_n = 0;
    logic tck = 0, tms = 1, tdi = 0;
    logic isp_mode = 0, read_secure = 0, bsr_so = 0, rd_req = 0;
    logic [31:0] usercode = 32'hFFFF_FFFF;
    logic tdo, tdo_oe, highz_req, clamp_req, bscan_sel, cfg_n, rd_grant;

    always #10 clk = ~clk;

    cfgmem_tap dut (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .isp_mode(isp_mode), .read_secure(read_secure),
        .usercode(usercode), .bsr_so(bsr_so), .highz_req(highz_req),
        .clamp_req(clamp_req), .bscan_sel(bscan_sel), .cfg_n(cfg_n),
        .rd_req(rd_req), .rd_grant(rd_grant)
    );

    int n_chk = 0, n_fail = 0;
    int m_st = T_RST;
    logic [7:0]  m_irs = 0, m_cur = 8'hFE;
    logic        m_byp = 0;
    logic [31:0] m_dr = 0;
    logic        last_tdo;
    int pulses[$];
    int low_cnt = 0;
    logic exp_g = 0, g_valid = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nxt(int s, bit m);
        case (s)
            T_RST: return m ? T_RST : T_IDLE;
            T_IDLE: return m ? T_SDR : T_IDLE;
            T_SDR: return m ? T_SIR : T_CDR;
            T_CDR, T_SHD: return m ? T_E1D : T_SHD;
            T_E1D: return m ? T_UDR : T_PD;
            T_PD: return m ? T_E2D : T_PD;
            T_E2D: return m ? T_UDR : T_SHD;
            T_UDR, T_UIR: return m ? T_SDR : T_IDLE;
            T_SIR: return m ? T_RST : T_CIR;
            T_CIR, T_SHI: return m ? T_E1I : T_SHI;
            T_E1I: return m ? T_UIR : T_PI;
            T_PI: return m ? T_E2I : T_PI;
            default: return m ? T_UIR : T_SHI;
        endcase
    endfunction

    function automatic bit is_bscan(logic [7:0] op);
        return op == 8'h00 || op == 8'h01;
    endfunction

    // One TCK period; compare outputs just before the rise, then advance model.
    task automatic step(input bit m, input bit d);
        bit exp_oe;
        logic exp_tdo;
        tck = 0; tms = m; tdi = d;
        repeat (HALF) @(negedge clk);
        exp_oe = (m_st == T_SHI) || (m_st == T_SHD);
        chk(tdo_oe == exp_oe, "R10 tdo_oe", {31'b0, tdo_oe}, {31'b0, exp_oe});
        if (exp_oe) begin
            if (m_st == T_SHI)                          exp_tdo = m_irs[0];
            else if (is_bscan(m_cur))                   exp_tdo = bsr_so;
            else if (m_cur == 8'hFE || m_cur == 8'hFD)  exp_tdo = m_dr[0];
            else                                        exp_tdo = m_byp;
            chk(tdo == exp_tdo, "R10 tdo", {31'b0, tdo}, {31'b0, exp_tdo});
        end
        chk(highz_req == (m_cur == 8'hFC), "R6 highz", {31'b0, highz_req}, {24'b0, m_cur});
        chk(clamp_req == (m_cur == 8'hFA), "R6 clamp", {31'b0, clamp_req}, {24'b0, m_cur});
        chk(bscan_sel == is_bscan(m_cur), "R7 bscan_sel", {31'b0, bscan_sel}, {24'b0, m_cur});
        last_tdo = tdo;
        case (m_st)
            T_RST: m_cur = 8'hFE;
            T_CIR: m_irs = {3'b000, isp_mode, read_secure, 1'b0, 2'b01};
            T_SHI: m_irs = {d, m_irs[7:1]};
            T_UIR: m_cur = m_irs;
            T_CDR: begin
                m_byp = 0;
                m_dr = (m_cur == 8'hFE) ? IDV : (m_cur == 8'hFD) ? usercode : 32'h0;
            end
            T_SHD: begin
                m_byp = d;
                m_dr = {d, m_dr[31:1]};
            end
            default: ;
        endcase
        m_st = nxt(m_st, m);
        tck = 1;
        repeat (HALF) @(negedge clk);
        bsr_so = ~bsr_so;
    endtask

    task automatic tap_reset();
        repeat (5) step(1, 0);
        step(0, 0);
    endtask

    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        cap = 0;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i]);
            cap[i] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = 0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    // Expected read grant from the inputs seen at each edge.
    always @(posedge clk) begin
        exp_g   <= rd_req & ~read_secure;
        g_valid <= rst_n;
    end

    // Per-clock check of the read gate (R9) and rd_req stimulus.
    always @(negedge clk) begin
        cyc++;
        if (g_valid && rst_n)
            chk(rd_grant == exp_g, "R9 rd_grant", {31'b0, rd_grant}, {31'b0, exp_g});
        rd_req = cyc[2] ^ cyc[0];
    end

    // cfg_n pulse width recorder.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_n) low_cnt++;
            else if (low_cnt > 0) begin
                pulses.push_back(low_cnt);
                low_cnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] cap;
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(cfg_n == 1'b1, "R11 cfg_n", {31'b0, cfg_n}, 32'h1);
        chk(tdo_oe == 1'b0, "R11 tdo_oe", {31'b0, tdo_oe}, 32'h0);
        step(0, 0);
        scan_dr(32, 32'h0, d);
        chk(d == IDV, "R11 default instruction IDCODE", d, IDV);

        // R2 capture pattern for each status combination
        for (int k = 0; k < 4; k++) begin
            isp_mode = k[0]; read_secure = k[1];
            scan_ir(8'hFF, cap);
            chk(cap == {3'b000, k[0], k[1], 3'b001}, "R2 capture pattern", {24'b0, cap},
                {27'b0, k[0], k[1], 3'b001});
        end
        isp_mode = 0; read_secure = 0;

        // R3 identity word
        scan_ir(8'hFE, cap);
        scan_dr(32, 32'h1234_5678, d);
        chk(d == IDV, "R3 IDCODE", d, IDV);

        // R4 user code, blank and programmed
        scan_ir(8'hFD, cap);
        scan_dr(32, 32'h0, d);
        chk(d == 32'hFFFF_FFFF, "R4 blank USERCODE", d, 32'hFFFF_FFFF);
        usercode = 32'hA5C3_0F96;
        scan_dr(32, 32'h0, d);
        chk(d == 32'hA5C3_0F96, "R4 USERCODE", d, 32'hA5C3_0F96);

        // R5 bypass and an unlisted opcode
        scan_ir(8'hFF, cap);
        scan_dr(8, 32'hB2, d);
        chk(d[7:0] == 8'h64, "R5 bypass delay", d, 32'h64);
        scan_ir(8'h5A, cap);
        scan_dr(8, 32'h6D, d);
        chk(d[7:0] == 8'hDA, "R5 unknown opcode bypass", d, 32'hDA);

        // R6 pin requests
        scan_ir(8'hFC, cap);
        chk(highz_req == 1'b1, "R6 HIGHZ request", {31'b0, highz_req}, 32'h1);
        scan_dr(4, 32'h9, d);
        chk(d[3:0] == 4'h2, "R6 HIGHZ uses bypass", d, 32'h2);
        scan_ir(8'hFA, cap);
        chk(clamp_req == 1'b1 && highz_req == 1'b0, "R6 CLAMP request", {30'b0, clamp_req, highz_req}, 32'h2);

        // R7 boundary chain routing
        scan_ir(8'h00, cap);
        chk(bscan_sel == 1'b1, "R7 EXTEST select", {31'b0, bscan_sel}, 32'h1);
        scan_dr(6, 32'h15, d);
        scan_ir(8'h01, cap);
        chk(bscan_sel == 1'b1, "R7 SAMPLE select", {31'b0, bscan_sel}, 32'h1);
        scan_dr(5, 32'h0A, d);

        // R8 configuration pulse
        pulses.delete();
        scan_ir(8'hEE, cap);
        repeat (10) step(0, 0);
        chk(pulses.size() == 1, "R8 one pulse", pulses.size(), 1);
        if (pulses.size() > 0) chk(pulses[0] == PW, "R8 pulse width", pulses[0], PW);
        scan_ir(8'hEE, cap);
        repeat (4) step(0, 0);
        chk(pulses.size() == 2, "R8 second CONFIG pulses again", pulses.size(), 2);
        if (pulses.size() > 1) chk(pulses[1] == PW, "R8 second width", pulses[1], PW);
        scan_ir(8'hFE, cap);
        repeat (4) step(0, 0);
        chk(pulses.size() == 2, "R8 no pulse for other opcode", pulses.size(), 2);

        // R1 reset through TMS from a mid-graph state
        scan_ir(8'hFC, cap);
        step(1, 0); step(0, 0); step(0, 0);
        tap_reset();
        chk(highz_req == 1'b0, "R1 reset clears HIGHZ", {31'b0, highz_req}, 32'h0);
        scan_dr(32, 32'h0, d);
        chk(d == IDV, "R1 IDCODE after TMS reset", d, IDV);

        // R9 protection blocks grants for a while
        read_secure = 1;
        repeat (40) @(negedge clk);
        read_secure = 0;
        repeat (40) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule